// File: doc/BRIEF.md
# Wide Flash Prefetch Buffer Controller

This block connects a 32-bit system bus read port to a slow non-volatile array whose reads return a whole 128-bit line. It holds a small set of line buffers. Each buffer has a valid bit and a line tag. A read that finds its line in a buffer gets its word back with no wait state. A read that misses issues a single line read to the array, stores the returned line in a buffer chosen by least-recently-used replacement, and returns the word one cycle after the array data arrives.

When prefetch is enabled, a demand fill is followed at once by a read of the next sequential line, unless that line is already held. While the prefetch is in flight, the bus is still served. Hits complete at full speed. A read of the line being prefetched waits for that fill instead of starting a second array read. A read of any other missing line is queued behind the prefetch. An invalidate input drops every buffer in one cycle, so the contents can be refreshed after the array has been rewritten.

The bus protocol works as follows. The master drives `bus_req` with a byte address and holds both until `bus_ready` is seen. In the cycle that carries `bus_ready`, the master may present its next request. The array side uses a one-cycle read strobe and a data-valid return, and the array may take any number of cycles to answer.

Top module: `pfb_ctrl`

## Requirements
- R1: After reset, `bus_ready` and `arr_rd` are low and every buffer is invalid, so the first read of any line misses.
- R2: The returned word is chosen by address bits [3:2]. Word k of a line occupies line bits [32k+31:32k]. The line address is the byte address shifted right by 4.
- R3: A request accepted while the block is idle or prefetching that hits a valid buffer gets `bus_ready` with the word in the next cycle (zero wait states).
- R4: A miss causes one `arr_rd` pulse carrying the line address. `bus_ready` with the word follows one cycle after `arr_rvalid`. With an array that answers in the cycle after the strobe, this makes exactly two wait states relative to a hit.
- R5: Array latency is not fixed. The block waits for `arr_rvalid` however long it takes, so a miss costs the latency plus one cycle of wait states.
- R6: At most one array read is outstanding, and a new `arr_rd` is issued only after the previous read has returned.
- R7: A fill goes to the lowest-numbered invalid buffer if there is one. Otherwise it goes to the least recently used buffer, where hits and fills both count as uses. A line is never held in two buffers.
- R8: A pulse on `inv` clears all valid bits in one cycle and wins over a fill in the same cycle. Afterwards, every read misses.
- R9: With `pf_en` high, each demand fill is followed in the next cycle by a read of the next line (address plus one, wrapping), unless that line is already held. With `pf_en` low, no read is issued beyond demand misses.
- R10: A request for the line being prefetched issues no further array read. It completes one cycle after that prefetch returns.
- R11: A request for another missing line made during a prefetch is sent to the array only after the prefetch has returned. A request seen in the very cycle the prefetch returns is held off for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_en | input | 1 | Enables next-line prefetch after demand fills |
| inv | input | 1 | Clears all buffer valid bits |
| bus_req | input | 1 | Read request, held until `bus_ready` |
| bus_addr | input | ADDR_W (16) | Byte address of the requested word |
| bus_ready | output | 1 | One-cycle completion strobe for a request |
| bus_rdata | output | WORD_W (32) | Read word, valid with `bus_ready` |
| arr_rd | output | 1 | One-cycle array line read strobe |
| arr_line | output | ADDR_W-4 (12) | Line address for the array read |
| arr_rvalid | input | 1 | Array line data valid |
| arr_rdata | input | LINE_W (128) | Array line data |

## Verification
Each read is driven on a falling edge, and the bench counts the falling edges that pass before `bus_ready` is seen high. The count is zero for a hit, two for a miss against a one-cycle array, one for a read that lands on the line being prefetched, three for an unrelated miss issued during a prefetch, and latency plus one for a slower array. Every expected count comes from the timing rules in the requirements, and the word is checked against an arithmetic pattern of line and word index. A counter kept at the array model records every `arr_rd` strobe. This shows how many reads each step has caused, which exposes missing, duplicate or suppressed prefetches and the evictions made by replacement.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_PF    = 2'd2,
    ST_PFW   = 2'd3
  } pfb_state_e;
endpackage

// File: rtl/pfb_tags.sv
module pfb_tags #(
  parameter int NBUF  = 4,
  parameter int TAG_W = 12,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TAG_W-1:0] look_a,
  input  logic [TAG_W-1:0] look_b,
  output logic [NBUF-1:0]  hit_a,
  output logic [NBUF-1:0]  hit_b,
  output logic [NBUF-1:0]  valid
);
  logic [NBUF-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [NBUF];

  for (genvar i = 0; i < NBUF; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst || inv)
        valid_q[i] <= 1'b0;
      else if (wr_en && wr_idx == IDX_W'(i))
        valid_q[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(i))
        tag_q[i] <= wr_tag;
    end

    assign hit_a[i] = valid_q[i] && (tag_q[i] == look_a);
    assign hit_b[i] = valid_q[i] && (tag_q[i] == look_b);
  end

  assign valid = valid_q;
endmodule

// File: rtl/pfb_lru.sv
module pfb_lru #(
  parameter int NBUF = 4,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [NBUF-1:0]  valid,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] age_q [NBUF];
  logic             any_free;

  for (genvar i = 0; i < NBUF; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst)
        age_q[i] <= IDX_W'(i);
      else if (touch) begin
        if (touch_idx == IDX_W'(i))
          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx])
          age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim   = '0;
    any_free = 1'b0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        victim   = IDX_W'(i);
        any_free = 1'b1;
      end
    end
    if (!any_free) begin
      for (int i = 0; i < NBUF; i++) begin
        if (age_q[i] == IDX_W'(NBUF - 1))
          victim = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pfb_data.sv
module pfb_data #(
  parameter int NBUF   = 4,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [LINE_W-1:0] wline,
  input  logic [IDX_W-1:0]  ridx,
  output logic [LINE_W-1:0] rline
);
  logic [LINE_W-1:0] mem [NBUF];

  always_ff @(posedge clk) begin
    if (we)
      mem[widx] <= wline;
  end

  assign rline = mem[ridx];
endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32,
  parameter int LINE_W = 128,
  parameter int NBUF   = 4,
  localparam int LANE_B = $clog2(WORD_W / 8),
  localparam int WSEL_W = $clog2(LINE_W / WORD_W),
  localparam int OFS_W  = LANE_B + WSEL_W,
  localparam int TAG_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pf_en,
  input  logic              inv,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ready,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              arr_rd,
  output logic [TAG_W-1:0]  arr_line,
  input  logic              arr_rvalid,
  input  logic [LINE_W-1:0] arr_rdata
);
  import pfb_pkg::*;
  localparam int IDX_W = $clog2(NBUF);

  pfb_state_e        st_q;
  logic [TAG_W-1:0]  pend_tag, pf_tag, nxt_tag, req_tag, fill_tag;
  logic [WSEL_W-1:0] pend_wsel, req_wsel;
  logic [NBUF-1:0]   hit_vec, pfhit_vec, valid_vec, victim_oh;
  logic [IDX_W-1:0]  hit_idx, victim, touch_idx;
  logic [LINE_W-1:0] buf_line;
  logic              hit, accept, fill_en, touch, pf_need;

  function automatic logic [WORD_W-1:0] pick(input logic [LINE_W-1:0] l,
                                             input logic [WSEL_W-1:0] s);
    return l[int'(s) * WORD_W +: WORD_W];
  endfunction

  assign req_tag   = bus_addr[ADDR_W-1:OFS_W];
  assign req_wsel  = bus_addr[OFS_W-1:LANE_B];
  assign nxt_tag   = pend_tag + 1'b1;
  assign hit       = |hit_vec;
  assign victim_oh = NBUF'(1) << victim;
  assign accept    = bus_req && (st_q == ST_IDLE || (st_q == ST_PF && !arr_rvalid));
  assign fill_en   = arr_rvalid && (st_q != ST_IDLE);
  assign fill_tag  = (st_q == ST_FETCH) ? pend_tag : pf_tag;
  assign pf_need   = pf_en && !(|(pfhit_vec & ~victim_oh));
  assign touch     = fill_en || (accept && hit);
  assign touch_idx = fill_en ? victim : hit_idx;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NBUF; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  pfb_tags #(.NBUF(NBUF), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .inv(inv),
    .wr_en(fill_en), .wr_idx(victim), .wr_tag(fill_tag),
    .look_a(req_tag), .look_b(nxt_tag),
    .hit_a(hit_vec), .hit_b(pfhit_vec), .valid(valid_vec)
  );

  pfb_lru #(.NBUF(NBUF)) u_lru (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
    .valid(valid_vec), .victim(victim)
  );

  pfb_data #(.NBUF(NBUF), .LINE_W(LINE_W)) u_data (
    .clk(clk), .we(fill_en), .widx(victim), .wline(arr_rdata),
    .ridx(hit_idx), .rline(buf_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      bus_ready <= 1'b0;
      bus_rdata <= '0;
      arr_rd    <= 1'b0;
      arr_line  <= '0;
      pend_tag  <= '0;
      pend_wsel <= '0;
      pf_tag    <= '0;
    end else begin
      bus_ready <= 1'b0;
      arr_rd    <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (hit) begin
              bus_ready <= 1'b1;
              bus_rdata <= pick(buf_line, req_wsel);
            end else begin
              pend_tag  <= req_tag;
              pend_wsel <= req_wsel;
              arr_rd    <= 1'b1;
              arr_line  <= req_tag;
              st_q      <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (arr_rvalid) begin
            bus_ready <= 1'b1;
            bus_rdata <= pick(arr_rdata, pend_wsel);
            if (pf_need) begin
              arr_rd   <= 1'b1;
              arr_line <= nxt_tag;
              pf_tag   <= nxt_tag;
              st_q     <= ST_PF;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_PF: begin
          if (arr_rvalid) begin
            st_q <= ST_IDLE;
          end else if (accept) begin
            if (hit) begin
              bus_ready <= 1'b1;
              bus_rdata <= pick(buf_line, req_wsel);
            end else begin
              pend_tag  <= req_tag;
              pend_wsel <= req_wsel;
              st_q      <= ST_PFW;
            end
          end
        end
        ST_PFW: begin
          if (arr_rvalid) begin
            if (pend_tag == pf_tag) begin
              bus_ready <= 1'b1;
              bus_rdata <= pick(arr_rdata, pend_wsel);
              st_q      <= ST_IDLE;
            end else begin
              arr_rd   <= 1'b1;
              arr_line <= pend_tag;
              st_q     <= ST_FETCH;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pfb_ctrl_chk.sv
module pfb_ctrl_chk #(
  parameter int NBUF = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               inv,
  input logic               bus_req,
  input logic               bus_ready,
  input logic               arr_rd,
  input logic               arr_rvalid,
  input pfb_pkg::pfb_state_e st,
  input logic               hit,
  input logic [NBUF-1:0]    hit_vec,
  input logic [NBUF-1:0]    valid
);
  import pfb_pkg::*;

  logic [1:0] outst;

  always_ff @(posedge clk) begin
    if (rst)
      outst <= '0;
    else begin
      case ({arr_rd, arr_rvalid})
        2'b10:   outst <= outst + 1'b1;
        2'b01:   outst <= (outst == 2'd0) ? 2'd0 : outst - 1'b1;
        default: outst <= outst;
      endcase
    end
  end

  // R6: a new line read only when nothing is outstanding
  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (rst)
    arr_rd |-> outst == 2'd0);

  // R3: hit while idle completes in the following cycle
  p_hit_next_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && bus_req && hit) |=> bus_ready);

  // R4: demand data return leads to completion one cycle later
  p_fill_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FETCH && arr_rvalid) |=> bus_ready);

  // R8: invalidate empties every buffer at once
  p_inv_clears_r8: assert property (@(posedge clk) disable iff (rst)
    inv |=> valid == '0);

  // R7: a line is never held twice
  p_unique_line_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

bind pfb_ctrl pfb_ctrl_chk #(.NBUF(NBUF)) u_chk (
  .clk(clk), .rst(rst), .inv(inv), .bus_req(bus_req), .bus_ready(bus_ready),
  .arr_rd(arr_rd), .arr_rvalid(arr_rvalid), .st(st_q), .hit(hit),
  .hit_vec(hit_vec), .valid(valid_vec)
);

// File: tb/pfb_ctrl_tb.sv
module pfb_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pf_en = 1'b0;
  logic         inv = 1'b0;
  logic         bus_req = 1'b0;
  logic [15:0]  bus_addr = '0;
  logic         bus_ready;
  logic [31:0]  bus_rdata;
  logic         arr_rd;
  logic [11:0]  arr_line;
  logic         arr_rvalid;
  logic [127:0] arr_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int n_rd = 0;
  int lat = 1;
  int m_cnt = 0;
  logic [11:0] m_line = '0;
  bit done = 0;

  always #4 clk = ~clk;

  pfb_ctrl u_dut (
    .clk(clk), .rst(rst), .pf_en(pf_en), .inv(inv),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .arr_rd(arr_rd), .arr_line(arr_line),
    .arr_rvalid(arr_rvalid), .arr_rdata(arr_rdata)
  );

  function automatic logic [31:0] wpat(input logic [11:0] l, input logic [1:0] w);
    return {8'hA5, 4'h0, l, 4'h0, 2'b00, w};
  endfunction

  // array model: answers lat cycles after the strobe
  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0;
    end else if (arr_rd) begin
      m_line <= arr_line;
      m_cnt  <= lat;
      n_rd   <= n_rd + 1;
    end else if (m_cnt != 0) begin
      m_cnt <= m_cnt - 1;
    end
  end

  assign arr_rvalid = (m_cnt == 1);
  always_comb
    for (int w = 0; w < 4; w++) arr_rdata[w*32 +: 32] = wpat(m_line, 2'(w));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] l, input logic [1:0] w, input int exp_wait,
                    input string rq);
    int waits;
    waits = 0;
    bus_req  = 1'b1;
    bus_addr = {l, w, 2'b00};
    @(negedge clk);
    while (!bus_ready && waits < 60) begin
      waits++;
      @(negedge clk);
    end
    bus_req = 1'b0;
    chk(waits == exp_wait, {rq, " wait states"}, waits, exp_wait);
    chk(bus_rdata == wpat(l, w), {rq, " data (R2)"}, bus_rdata, wpat(l, w));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_inv();
    inv = 1'b1;
    @(negedge clk);
    inv = 1'b0;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_ready && !arr_rd, "R1 reset outputs", {bus_ready, arr_rd}, 0);

    // R1/R4: first read misses; no prefetch with pf_en low (R9)
    base = n_rd;
    rd(12'h000, 2'd0, 2, "R1 R4 first miss");
    chk(n_rd == base + 1, "R9 no prefetch when disabled", n_rd - base, 1);
    for (int w = 1; w < 4; w++) rd(12'h000, 2'(w), 0, "R3 hit word");

    // fill lines 1..3 then sweep all words (R2, R3)
    for (int l = 1; l < 4; l++) rd(12'(l), 2'd3, 2, "R4 miss line");
    for (int l = 0; l < 4; l++)
      for (int w = 0; w < 4; w++) rd(12'(l), 2'(w), 0, "R3 sweep hit");

    // R7: LRU eviction
    rd(12'h000, 2'd1, 0, "R7 touch line0");
    base = n_rd;
    rd(12'h004, 2'd2, 2, "R7 new line");
    rd(12'h000, 2'd0, 0, "R7 line0 kept");
    rd(12'h002, 2'd0, 0, "R7 line2 kept");
    rd(12'h003, 2'd0, 0, "R7 line3 kept");
    rd(12'h001, 2'd0, 2, "R7 line1 evicted");
    chk(n_rd == base + 2, "R7 read count", n_rd - base, 2);

    // R8: invalidate
    do_inv();
    rd(12'h000, 2'd0, 2, "R8 miss after inv");
    rd(12'h003, 2'd1, 2, "R8 line3 miss after inv");

    // R9: prefetch then hit
    pf_en = 1'b1;
    do_inv();
    base = n_rd;
    rd(12'h010, 2'd0, 2, "R9 demand");
    idle(4);
    rd(12'h011, 2'd2, 0, "R9 prefetched hit");
    chk(n_rd == base + 2, "R9 read count", n_rd - base, 2);

    // R10: read of in-flight line waits for it
    do_inv();
    base = n_rd;
    rd(12'h020, 2'd1, 2, "R10 demand");
    rd(12'h021, 2'd3, 1, "R10 in-flight line");
    chk(n_rd == base + 2, "R10 no second read", n_rd - base, 2);
    idle(4);

    // R3 during prefetch
    do_inv();
    base = n_rd;
    rd(12'h028, 2'd0, 2, "R3 demand");
    rd(12'h028, 2'd1, 0, "R3 hit during prefetch");
    idle(4);
    rd(12'h029, 2'd0, 0, "R9 after hit");
    chk(n_rd == base + 2, "R3 read count", n_rd - base, 2);

    // R11: other miss queued behind prefetch
    do_inv();
    base = n_rd;
    rd(12'h032, 2'd0, 2, "R11 demand");
    rd(12'h03C, 2'd2, 3, "R11 queued miss");
    idle(4);
    chk(n_rd == base + 4, "R11 read count", n_rd - base, 4);

    // R9: prefetch suppressed when next line held
    do_inv();
    pf_en = 1'b0;
    base = n_rd;
    rd(12'h047, 2'd0, 2, "R9 preload");
    pf_en = 1'b1;
    rd(12'h046, 2'd0, 2, "R9 demand");
    idle(4);
    rd(12'h047, 2'd1, 0, "R9 held line hit");
    chk(n_rd == base + 2, "R9 suppressed prefetch", n_rd - base, 2);

    // R5: slower array
    pf_en = 1'b0;
    lat = 3;
    do_inv();
    rd(12'h200, 2'd3, 4, "R5 slow array miss");
    rd(12'h200, 2'd0, 0, "R5 slow array hit");
    lat = 5;
    rd(12'h201, 2'd1, 6, "R5 slower array miss");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule